// File: doc/BRIEF.md
# Time-Slotted Shared Memory Bus Arbiter

This block lets two engines that run at the same time share one 64-bit memory port. One of them is a polynomial-multiply engine that has a fixed rhythm. Within every four cycles it loads operands once and stores a result once, and for the other two cycles it leaves the bus alone. The other is a companion engine, such as an integer sorter or a polynomial inverter, whose accesses are shaped to fit those two quiet cycles. The arbiter runs a free-running frame counter. The first `MUL_SLOTS` phases of each frame belong to the multiplier and the rest belong to the companion. In each cycle it grants at most one requester and routes that requester's address, write enable and write data onto the memory port. This fills the bus without making it wider. The two engines may only run together when their operands are independent, so the arbiter never orders one engine's data against the other's.

Grants are combinational in the same cycle as the request. A requester that is not granted keeps its request and address steady until it is granted. If the owner of the current phase is not requesting, the other requester may use that cycle. This means an engine running alone gets every cycle, while the frame counter keeps turning so that the second engine can join at a clean boundary. Read data arrives one cycle after a read grant, flagged by a per-requester valid strobe. Two counters, one for total cycles and one for busy bus cycles, let an observer compute bus utilization.

Top module: `slotted_bus_arb`

## Requirements
- R1: While reset is held, `slot_phase`, `busy_cnt`, `total_cnt`, `mul_rvalid` and `cmp_rvalid` are all zero. `mul_rdata` and `cmp_rdata` read zero whenever their valid strobe is low.
- R2: After reset is released, `slot_phase` starts at 0 in the first cycle and advances by one on every clock. It wraps from `FRAME_LEN-1` back to 0 whatever the requests are.
- R3: In phases below `MUL_SLOTS` (phases 0 and 1 by default), a requesting multiplier is granted and the companion is not.
- R4: In phases at or above `MUL_SLOTS` (phases 2 and 3 by default), a requesting companion is granted and the multiplier is not.
- R5: When only one requester asserts its request, it is granted in that cycle whatever the phase.
- R6: At most one grant is high in any cycle. `mem_en` is high exactly when a grant is high, and `mem_addr`, `mem_we` and `mem_wdata` then carry the granted requester's values. With no request, `mem_en` is low.
- R7: One cycle after a read grant (grant high with write enable low), that requester's `rvalid` is high and its `rdata` equals `mem_rdata`. The other requester's `rvalid` is low. A write grant produces no `rvalid`.
- R8: `total_cnt` rises by one on every clock after reset. `busy_cnt` rises by one on every clock in which `mem_en` was high. Both wrap at their width.
- R9: With both engines requesting all the time, the bus is busy every cycle and each engine receives exactly half of the cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_req | input | 1 | Multiply engine bus request |
| mul_we | input | 1 | Multiply engine write enable (1 = write) |
| mul_addr | input | ADDR_W | Multiply engine word address |
| mul_wdata | input | DATA_W | Multiply engine write data |
| mul_gnt | output | 1 | Multiply engine granted this cycle |
| mul_rvalid | output | 1 | Read data for the multiply engine is valid |
| mul_rdata | output | DATA_W | Read data for the multiply engine |
| cmp_req | input | 1 | Companion engine bus request |
| cmp_we | input | 1 | Companion engine write enable (1 = write) |
| cmp_addr | input | ADDR_W | Companion engine word address |
| cmp_wdata | input | DATA_W | Companion engine write data |
| cmp_gnt | output | 1 | Companion engine granted this cycle |
| cmp_rvalid | output | 1 | Read data for the companion engine is valid |
| cmp_rdata | output | DATA_W | Read data for the companion engine |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the access |
| slot_phase | output | PHASE_W | Current phase of the time-division frame |
| busy_cnt | output | CNT_W | Cycles in which the bus carried an access |
| total_cnt | output | CNT_W | Cycles since reset |

## Verification
Two things overlap in the same cycle. The first is the return of read data to one engine, which comes from the previous cycle's grant. The second is a fresh grant, often through fallback, to the other engine. The bench provokes this by issuing a multiplier read and then, in the very next cycle, a companion read during a companion phase. It then judges three things: the multiplier's `rvalid` and data match the memory model, the companion's grant and bus fields are correct in that same cycle, and the companion's own data lands one cycle later with the multiplier's strobe low. A second overlap is between a phase owner's grant and the other engine's held request. Sustained contention exercises this, and the bench checks that exactly one grant appears per cycle and that the grants split evenly.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MUL  = 2'd1,
    SEL_CMP  = 2'd2
  } bus_sel_e;

  // Phase ownership: the multiplier owns the low phases of each frame.
  function automatic logic mul_owns_phase(input int unsigned phase, input int unsigned mul_slots);
    return phase < mul_slots;
  endfunction

  // Winner selection: the phase owner first, then the other requester as fallback.
  function automatic bus_sel_e pick_winner(input logic mul_owner, input logic mreq, input logic creq);
    bus_sel_e s;
    if (mul_owner) s = mreq ? SEL_MUL : (creq ? SEL_CMP : SEL_NONE);
    else           s = creq ? SEL_CMP : (mreq ? SEL_MUL : SEL_NONE);
    return s;
  endfunction

endpackage

// File: rtl/arb_phase_ctr.sv
module arb_phase_ctr #(
  parameter int FRAME_LEN = 4,
  parameter int PHASE_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(FRAME_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/arb_slot_grant.sv
module arb_slot_grant
  import slot_arb_pkg::*;
#(
  parameter int PHASE_W   = 2,
  parameter int MUL_SLOTS = 2
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic               mul_req,
  input  logic               cmp_req,
  output bus_sel_e           sel,
  output logic               mul_gnt,
  output logic               cmp_gnt
);
  logic mul_owner;

  always_comb begin
    mul_owner = mul_owns_phase(int'(phase), MUL_SLOTS);
    sel       = pick_winner(mul_owner, mul_req, cmp_req);
    mul_gnt   = (sel == SEL_MUL);
    cmp_gnt   = (sel == SEL_CMP);
  end
endmodule

// File: rtl/arb_bus_route.sv
module arb_bus_route
  import slot_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_sel_e          sel,
  input  logic              mul_we,
  input  logic [ADDR_W-1:0] mul_addr,
  input  logic [DATA_W-1:0] mul_wdata,
  input  logic              cmp_we,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] cmp_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mul_rvalid,
  output logic [DATA_W-1:0] mul_rdata,
  output logic              cmp_rvalid,
  output logic [DATA_W-1:0] cmp_rdata
);
  logic mul_rd_now, cmp_rd_now;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (sel)
      SEL_MUL: begin
        mem_en = 1'b1; mem_we = mul_we; mem_addr = mul_addr; mem_wdata = mul_wdata;
      end
      SEL_CMP: begin
        mem_en = 1'b1; mem_we = cmp_we; mem_addr = cmp_addr; mem_wdata = cmp_wdata;
      end
      default: ;
    endcase
    mul_rd_now = (sel == SEL_MUL) && !mul_we;
    cmp_rd_now = (sel == SEL_CMP) && !cmp_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_rvalid <= 1'b0;
      cmp_rvalid <= 1'b0;
    end else begin
      mul_rvalid <= mul_rd_now;
      cmp_rvalid <= cmp_rd_now;
    end
  end

  assign mul_rdata = mul_rvalid ? mem_rdata : '0;
  assign cmp_rdata = cmp_rvalid ? mem_rdata : '0;
endmodule

// File: rtl/arb_util_cnt.sv
module arb_util_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/slotted_bus_arb.sv
module slotted_bus_arb
  import slot_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int FRAME_LEN = 4,
  parameter int MUL_SLOTS = 2,
  parameter int CNT_W     = 32,
  localparam int PHASE_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mul_req,
  input  logic               mul_we,
  input  logic [ADDR_W-1:0]  mul_addr,
  input  logic [DATA_W-1:0]  mul_wdata,
  output logic               mul_gnt,
  output logic               mul_rvalid,
  output logic [DATA_W-1:0]  mul_rdata,
  input  logic               cmp_req,
  input  logic               cmp_we,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [DATA_W-1:0]  cmp_wdata,
  output logic               cmp_gnt,
  output logic               cmp_rvalid,
  output logic [DATA_W-1:0]  cmp_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [PHASE_W-1:0] slot_phase,
  output logic [CNT_W-1:0]   busy_cnt,
  output logic [CNT_W-1:0]   total_cnt
);
  localparam int N_CNT = 2;

  bus_sel_e         sel;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  arb_phase_ctr #(.FRAME_LEN(FRAME_LEN), .PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase)
  );

  arb_slot_grant #(.PHASE_W(PHASE_W), .MUL_SLOTS(MUL_SLOTS)) u_grant (
    .phase(slot_phase), .mul_req(mul_req), .cmp_req(cmp_req),
    .sel(sel), .mul_gnt(mul_gnt), .cmp_gnt(cmp_gnt)
  );

  arb_bus_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .mul_we(mul_we), .mul_addr(mul_addr), .mul_wdata(mul_wdata),
    .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mul_rvalid(mul_rvalid), .mul_rdata(mul_rdata),
    .cmp_rvalid(cmp_rvalid), .cmp_rdata(cmp_rdata)
  );

  // index 0: busy cycles, index 1: all cycles
  assign cnt_inc = {1'b1, mem_en};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    arb_util_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .count(cnt_val[g])
    );
  end

  assign busy_cnt  = cnt_val[0];
  assign total_cnt = cnt_val[1];
endmodule

// File: rtl/slotted_bus_arb_chk.sv
module slotted_bus_arb_chk #(
  parameter int MUL_SLOTS = 2,
  parameter int PHASE_W   = 2,
  parameter int CNT_W     = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mul_req,
  input logic               mul_we,
  input logic               mul_gnt,
  input logic               mul_rvalid,
  input logic               cmp_req,
  input logic               cmp_we,
  input logic               cmp_gnt,
  input logic               cmp_rvalid,
  input logic               mem_en,
  input logic [PHASE_W-1:0] slot_phase,
  input logic [CNT_W-1:0]   busy_cnt,
  input logic [CNT_W-1:0]   total_cnt
);
  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_gnt, cmp_gnt}));

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul_req && !cmp_req) |-> !mem_en);

  // R3
  mul_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_phase) < MUL_SLOTS && mul_req) |-> (mul_gnt && !cmp_gnt));

  // R4
  cmp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_phase) >= MUL_SLOTS && cmp_req) |-> (cmp_gnt && !mul_gnt));

  // R5
  lone_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_req && !cmp_req) |-> mul_gnt);

  // R5
  lone_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !mul_req) |-> cmp_gnt);

  // R2
  phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_phase != $past(slot_phase)));

  // R7
  mul_rd_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_gnt && !mul_we) |=> (mul_rvalid && !cmp_rvalid));

  // R7
  cmp_rd_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_gnt && !cmp_we) |=> (cmp_rvalid && !mul_rvalid));

  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total_cnt == CNT_W'($past(total_cnt) + 1'b1)));

  // R8
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> (busy_cnt == CNT_W'($past(busy_cnt) + 1'b1)));
endmodule

bind slotted_bus_arb slotted_bus_arb_chk #(
  .MUL_SLOTS(MUL_SLOTS), .PHASE_W(PHASE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mul_req(mul_req), .mul_we(mul_we), .mul_gnt(mul_gnt), .mul_rvalid(mul_rvalid),
  .cmp_req(cmp_req), .cmp_we(cmp_we), .cmp_gnt(cmp_gnt), .cmp_rvalid(cmp_rvalid),
  .mem_en(mem_en), .slot_phase(slot_phase), .busy_cnt(busy_cnt), .total_cnt(total_cnt)
);

// File: tb/slotted_bus_arb_tb_top.sv
module slotted_bus_arb_tb_top;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int CW = 32;
  localparam int NV = 16;

  // {mul_req, cmp_req, exp_mul_gnt, exp_cmp_gnt}; vector i runs in phase i%4
  localparam logic [3:0] VEC [NV] = '{
    4'b1110, 4'b1110, 4'b1101, 4'b1101,
    4'b0101, 4'b0101, 4'b1010, 4'b1010,
    4'b0000, 4'b1010, 4'b0101, 4'b1101,
    4'b1110, 4'b0000, 4'b1101, 4'b0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mul_req = 0, mul_we = 0, cmp_req = 0, cmp_we = 0;
  logic [AW-1:0] mul_addr = '0, cmp_addr = '0;
  logic [DW-1:0] mul_wdata = '0, cmp_wdata = '0;
  logic mul_gnt, mul_rvalid, cmp_gnt, cmp_rvalid;
  logic [DW-1:0] mul_rdata, cmp_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0] slot_phase;
  logic [CW-1:0] busy_cnt, total_cnt;

  logic [DW-1:0] mem [16];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  slotted_bus_arb dut_i (
    .clk(clk), .rst_n(rst_n),
    .mul_req(mul_req), .mul_we(mul_we), .mul_addr(mul_addr), .mul_wdata(mul_wdata),
    .mul_gnt(mul_gnt), .mul_rvalid(mul_rvalid), .mul_rdata(mul_rdata),
    .cmp_req(cmp_req), .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata),
    .cmp_gnt(cmp_gnt), .cmp_rvalid(cmp_rvalid), .cmp_rdata(cmp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .slot_phase(slot_phase),
    .busy_cnt(busy_cnt), .total_cnt(total_cnt)
  );

  // memory model: synchronous, read data one cycle after the access
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[3:0]];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic mr, input logic mw, input logic [AW-1:0] ma,
                       input logic cr, input logic cw, input logic [AW-1:0] ca);
    mul_req = mr; mul_we = mw; mul_addr = ma; mul_wdata = 64'hA100_0000_0000_0000 | 64'(ma);
    cmp_req = cr; cmp_we = cw; cmp_addr = ca; cmp_wdata = 64'hC200_0000_0000_0000 | 64'(ca);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_rd;
    logic [CW-1:0] b0;
    int mg_n, cg_n;
    for (int k = 0; k < 16; k++) mem[k] = {32'(k) * 32'h0101_0101, ~(32'(k) * 32'h0011_0011)};

    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 phase", 64'(slot_phase), 0);
    chk("R1 busy", 64'(busy_cnt), 0);
    chk("R1 total", 64'(total_cnt), 0);
    chk("R1 rvalid", {62'd0, mul_rvalid, cmp_rvalid}, 0);
    chk("R1 rdata", mul_rdata | cmp_rdata, 0);

    // vector table: R2 R3 R4 R5 R6
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic mw, cw, emg, ecg;
      if (i > 0) @(negedge clk);
      mw = i[0]; cw = ~i[0];
      drive(VEC[i][3], mw, AW'(i), VEC[i][2], cw, AW'(8 + i));
      emg = VEC[i][1]; ecg = VEC[i][0];
      #2;
      chk("R2 phase", 64'(slot_phase), 64'(i % 4));
      chk("R3/R4/R5 mul_gnt", 64'(mul_gnt), 64'(emg));
      chk("R3/R4/R5 cmp_gnt", 64'(cmp_gnt), 64'(ecg));
      chk("R6 mem_en", 64'(mem_en), 64'(emg | ecg));
      if (emg) begin
        chk("R6 mem_addr mul", 64'(mem_addr), 64'(i));
        chk("R6 mem_we mul", 64'(mem_we), 64'(mw));
        chk("R6 mem_wdata mul", mem_wdata, 64'hA100_0000_0000_0000 | 64'(i));
      end
      if (ecg) begin
        chk("R6 mem_addr cmp", 64'(mem_addr), 64'(8 + i));
        chk("R6 mem_we cmp", 64'(mem_we), 64'(cw));
      end
    end

    // R8: 13 busy cycles in 16
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    #2;
    chk("R8 busy", 64'(busy_cnt), 13);
    chk("R8 total", 64'(total_cnt), 16);
    chk("R6 idle", 64'(mem_en), 0);

    // R7: multiplier read, then companion read overlapping its return
    @(negedge clk);
    drive(1, 0, 3, 0, 0, 0);
    exp_rd = mem[3];
    #2;
    chk("R5 mul read gnt", 64'(mul_gnt), 1);
    @(negedge clk);
    drive(0, 0, 0, 1, 0, 5);
    #2;
    chk("R7 mul_rvalid", 64'(mul_rvalid), 1);
    chk("R7 mul_rdata", mul_rdata, exp_rd);
    chk("R7 cmp_rvalid quiet", 64'(cmp_rvalid), 0);
    chk("R4 cmp gnt", 64'(cmp_gnt), 1);
    chk("R6 cmp addr", 64'(mem_addr), 5);
    exp_rd = mem[5];
    @(negedge clk);
    drive(0, 0, 0, 1, 1, 6);
    #2;
    chk("R7 cmp_rvalid", 64'(cmp_rvalid), 1);
    chk("R7 cmp_rdata", cmp_rdata, exp_rd);
    chk("R7 mul_rvalid low", 64'(mul_rvalid), 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    #2;
    chk("R7 write no rvalid", 64'(cmp_rvalid), 0);
    chk("R1 rdata gated", cmp_rdata, 0);
    chk("R6 write landed", mem[6], 64'hC200_0000_0000_0006);

    // R9: sustained contention
    b0 = busy_cnt; mg_n = 0; cg_n = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      drive(1, 0, AW'(c % 16), 1, 0, AW'((c + 7) % 16));
      #2;
      if (mul_gnt) mg_n++;
      if (cmp_gnt) cg_n++;
      if (mul_gnt == cmp_gnt) chk("R9 single grant", {62'd0, mul_gnt, cmp_gnt}, 64'd1);
    end
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    #2;
    chk("R9 busy every cycle", 64'(busy_cnt - b0), 40);
    chk("R9 mul share", 64'(mg_n), 20);
    chk("R9 cmp share", 64'(cg_n), 20);

    // R1: reset again mid-run
    rst_n = 1'b0;
    #2;
    chk("R1 re-reset phase", 64'(slot_phase), 0);
    chk("R1 re-reset total", 64'(total_cnt), 0);
    chk("R1 re-reset busy", 64'(busy_cnt), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule